// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Snapshot Key FIFO

This block scans a key matrix of up to 16 rows by 8 columns. It drives one row line at a time and watches the column lines. A column counts as pressed in a row only if it stays high for the whole time that row is driven. That time is 16 cycles plus a programmable debounce count. At the end of every complete scan, the block copies the set of pressed keys into an 8-entry key FIFO. Each entry is one byte. Host software reads the FIFO as two packed 32-bit words.

Two interrupt sources share one output line:
- A FIFO-count status bit, raised when the number of valid entries reaches a programmed threshold.
- A key-press status bit, raised when a pressed key is found at a position that the per-row wake masks leave open.

The register port is a plain synchronous write port with a combinational read. There is no handshake and no back-pressure. A write lands on the next clock edge. A read returns the current register value in the same cycle and has no side effect. In particular, reading the FIFO words never pops anything, because the FIFO contents are replaced wholesale once per scan.

Top module: `keymatrix_scanner`

## Requirements
- R1: After reset:
  - no row line is driven and `irq_o` is low;
  - the control word (address 0x00) reads 0, the status word (0x04) reads 0, and both FIFO words (0x30, 0x34) read 0.
- R2: While control bit 0 (enable) is 0:
  - no row line is driven;
  - the FIFO contents are not updated, whatever the column lines show.
- R3: Row timing:
  - when enabled, rows are driven one at a time in ascending order, row 0 first;
  - each row is held for exactly 16+D cycles, where D is control bits 13:4.
- R4: Scan period:
  - the first cycle of row 0 recurs every 6 + N·(16+D) + G cycles;
  - N is the row count and G is the gap register at address 0x2C, bits 15:0;
  - the period is made up of a 5-cycle lead-in, the row windows, one publish cycle and G gap cycles.
- R5: A key is recorded for a row only if its column line is high in every cycle of that row's window. A single-cycle drop removes it from that scan's snapshot.
- R6: Entry format and ordering:
  - entry format: bit 7 valid, bits 6:3 row, bits 2:0 column;
  - entries are ordered by ascending row, then ascending column;
  - entry k sits in byte k mod 4 of word 0x30 for k<4, and of word 0x34 for k≥4.
- R7: Entry limit:
  - at most 8 entries are published and further pressed keys are dropped;
  - unused entries read as 0;
  - status word bits 7:4 give the number of valid entries.
- R8: FIFO-count status (status bit 2):
  - it becomes 1 when control bit 3 is 1 and the entry count is at least the threshold in control bits 17:14;
  - writing 1 to bit 2 of the status word clears it unless the condition still holds.
- R9: Key-press status (status bit 0):
  - it becomes 1 when control bit 1 is 1 and a recorded key in row r has its column bit clear in the mask word at 0x38+4·r (bit c masks column c);
  - writing 1 to bit 0 of the status word clears it.
- R10: `irq_o` is high exactly when some status bit is 1 and its enable bit (bit 3 for status bit 2, bit 1 for status bit 0) is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| irq_o | output | 1 | Interrupt, OR of enabled status bits |
| row_drive_o | output | NROWS | Row lines, at most one high |
| col_sense_i | input | NCOLS | Column lines, high when a key in the driven row is closed |

## Verification
Result timing:
- A changed key pattern is only guaranteed to appear in the FIFO after one full scan that starts after the change has completed.
- The snapshot is published on the edge that ends the publish cycle, which always precedes the next first cycle of row 0.
- Status bits follow one cycle after their cause: the row end for key-press status, and the published count for FIFO-count status.

How the bench keeps to this timing:
- It never samples at a predicted cycle count after a stimulus. Instead it detects the first cycle of row 0 on the row lines.
- After changing the matrix it waits for two such starts, then reads the registers.
- Scan timing itself is measured by counting cycles between those starts and comparing them with the arithmetic period.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int ROW_W    = 4;
  localparam int COL_W    = 3;
  localparam int ENTRY_W  = 1 + ROW_W + COL_W;
  localparam int DEPTH    = 8;                 // fixed by the two packed readout words
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int DEB_W    = 10;
  localparam int THR_W    = 4;
  localparam int GAP_W    = 16;
  localparam int LEAD_CYC = 5;
  localparam int ROW_BASE = 16;
  localparam int MAX_ROWS = 1 << ROW_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] A_GAP  = 8'h2C;
  localparam logic [ADDR_W-1:0] A_ENT0 = 8'h30;
  localparam logic [ADDR_W-1:0] A_ENT1 = 8'h34;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h38;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_ROW,
    SQ_PUB,
    SQ_GAP
  } sq_state_t;
endpackage

// File: rtl/kps_scan_seq.sv
module kps_scan_seq
  import kps_pkg::*;
#(
  parameter int NROWS = 16,
  parameter int NCOLS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DEB_W-1:0] deb_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [NCOLS-1:0] col_i,
  output logic [NROWS-1:0] row_o,
  output logic             row_done_o,
  output logic [ROW_W-1:0] row_idx_o,
  output logic [NCOLS-1:0] row_bits_o,
  output logic             scan_done_o
);
  localparam int TW = GAP_W + 1;

  sq_state_t        st_q;
  logic [TW-1:0]    tick_q;
  logic [ROW_W-1:0] row_q;
  logic [NCOLS-1:0] acc_q;
  logic [NCOLS-1:0] acc_now;
  logic [TW-1:0]    row_last;
  logic             row_end;
  logic             last_row;

  assign row_last = TW'(ROW_BASE - 1) + TW'(deb_i);
  assign row_end  = (st_q == SQ_ROW) && (tick_q >= row_last);
  assign last_row = (row_q == ROW_W'(NROWS - 1));
  assign acc_now  = (tick_q == '0) ? col_i : (acc_q & col_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      tick_q <= '0;
      row_q  <= '0;
      acc_q  <= '0;
    end else if (!en_i) begin
      st_q   <= SQ_IDLE;
      tick_q <= '0;
      row_q  <= '0;
    end else begin
      acc_q <= acc_now;
      case (st_q)
        SQ_IDLE: begin
          st_q   <= SQ_LEAD;
          tick_q <= '0;
        end
        SQ_LEAD: begin
          if (tick_q >= TW'(LEAD_CYC - 1)) begin
            st_q   <= SQ_ROW;
            tick_q <= '0;
            row_q  <= '0;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        SQ_ROW: begin
          if (row_end) begin
            tick_q <= '0;
            if (last_row) st_q <= SQ_PUB;
            else          row_q <= row_q + 1'b1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        SQ_PUB: begin
          tick_q <= '0;
          st_q   <= (gap_i == '0) ? SQ_LEAD : SQ_GAP;
        end
        default: begin
          if ((tick_q + 1'b1) >= TW'(gap_i)) begin
            st_q   <= SQ_LEAD;
            tick_q <= '0;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign row_o       = (st_q == SQ_ROW) ? (NROWS'(1) << row_q) : '0;
  assign row_done_o  = row_end;
  assign row_idx_o   = row_q;
  assign row_bits_o  = acc_now;
  assign scan_done_o = (st_q == SQ_PUB);

  p_one_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_o));
  p_idle_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (row_o == '0));
endmodule

// File: rtl/kps_collect.sv
module kps_collect
  import kps_pkg::*;
#(
  parameter int NCOLS = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic                            row_done_i,
  input  logic [ROW_W-1:0]                row_idx_i,
  input  logic [NCOLS-1:0]                row_bits_i,
  input  logic                            scan_done_i,
  output logic [DEPTH-1:0][ENTRY_W-1:0]   ent_o,
  output logic [CNT_W-1:0]                cnt_o
);
  localparam int SUM_W = $clog2(DEPTH + NCOLS + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][ENTRY_W-1:0] stage_q;
  logic [CNT_W-1:0]              stcnt_q;
  logic [SUM_W-1:0]              slot [NCOLS];
  logic [SUM_W-1:0]              run_sum;

  always_comb begin
    run_sum = SUM_W'(stcnt_q);
    for (int j = 0; j < NCOLS; j++) begin
      slot[j] = run_sum;
      run_sum = run_sum + SUM_W'(row_bits_i[j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      stcnt_q <= '0;
      ent_o   <= '0;
      cnt_o   <= '0;
    end else if (clr_i) begin
      stage_q <= '0;
      stcnt_q <= '0;
    end else if (scan_done_i) begin
      ent_o   <= stage_q;
      cnt_o   <= stcnt_q;
      stage_q <= '0;
      stcnt_q <= '0;
    end else if (row_done_i) begin
      for (int j = 0; j < NCOLS; j++) begin
        if (row_bits_i[j] && (slot[j] < SUM_W'(DEPTH)))
          stage_q[slot[j][IDX_W-1:0]] <= {1'b1, row_idx_i, COL_W'(j)};
      end
      stcnt_q <= (run_sum >= SUM_W'(DEPTH)) ? CNT_W'(DEPTH) : run_sum[CNT_W-1:0];
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_W'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    p_valid_packed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_o[i][ENTRY_W-1] == (CNT_W'(i) < cnt_o));
  end
endmodule

// File: rtl/kps_regs.sv
module kps_regs
  import kps_pkg::*;
#(
  parameter int NROWS = 16,
  parameter int NCOLS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          en_o,
  output logic [DEB_W-1:0]              deb_o,
  output logic [GAP_W-1:0]              gap_o,
  output logic                          irq_o,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [DEPTH-1:0][ENTRY_W-1:0] ent_i,
  input  logic                          row_done_i,
  input  logic [ROW_W-1:0]              row_idx_i,
  input  logic [NCOLS-1:0]              row_bits_i
);
  logic             kp_en_q, fifo_en_q, kp_st_q, fifo_st_q;
  logic [THR_W-1:0] thr_q;
  logic [NCOLS-1:0] mask_q [MAX_ROWS];
  logic [ADDR_W-1:0] moff;
  logic [ROW_W-1:0]  midx;
  logic              mask_sel, kp_set, fifo_set, stat_wr;

  assign moff     = addr_i - A_MASK;
  assign midx     = moff[ROW_W+1:2];
  assign mask_sel = (addr_i >= A_MASK) && (moff[1:0] == 2'b00) &&
                    (moff[ADDR_W-1:2] < (ADDR_W-2)'(NROWS));
  assign stat_wr  = wr_i && (addr_i == A_STAT);
  assign kp_set   = row_done_i && kp_en_q && |(row_bits_i & ~mask_q[row_idx_i]);
  assign fifo_set = fifo_en_q && (cnt_i >= CNT_W'(thr_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0; kp_en_q <= 1'b0; fifo_en_q <= 1'b0;
      deb_o <= '0; thr_q <= '0; gap_o <= '0;
      kp_st_q <= 1'b0; fifo_st_q <= 1'b0;
      for (int r = 0; r < MAX_ROWS; r++) mask_q[r] <= '0;
    end else begin
      if (wr_i && addr_i == A_CTRL) begin
        en_o      <= wdata_i[0];
        kp_en_q   <= wdata_i[1];
        fifo_en_q <= wdata_i[3];
        deb_o     <= wdata_i[4 +: DEB_W];
        thr_q     <= wdata_i[14 +: THR_W];
      end
      if (wr_i && addr_i == A_GAP) gap_o <= wdata_i[GAP_W-1:0];
      if (wr_i && mask_sel) mask_q[midx] <= wdata_i[NCOLS-1:0];
      kp_st_q   <= (kp_st_q   & ~(stat_wr & wdata_i[0])) | kp_set;
      fifo_st_q <= (fifo_st_q & ~(stat_wr & wdata_i[2])) | fifo_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)
      rdata_o = {14'b0, thr_q, deb_o, fifo_en_q, 1'b0, kp_en_q, en_o};
    else if (addr_i == A_STAT)
      rdata_o = {24'b0, 4'(cnt_i), 1'b0, fifo_st_q, 1'b0, kp_st_q};
    else if (addr_i == A_GAP)
      rdata_o = 32'(gap_o);
    else if (addr_i == A_ENT0)
      rdata_o = {ent_i[3], ent_i[2], ent_i[1], ent_i[0]};
    else if (addr_i == A_ENT1)
      rdata_o = {ent_i[7], ent_i[6], ent_i[5], ent_i[4]};
    else if (mask_sel)
      rdata_o = 32'(mask_q[midx]);
  end

  assign irq_o = (kp_st_q & kp_en_q) | (fifo_st_q & fifo_en_q);

  p_fifo_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_st_q) |-> $past(fifo_en_q && (cnt_i >= CNT_W'(thr_q))));
  p_kp_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wdata_i[0] && !row_done_i) |=> !kp_st_q);
  p_irq_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (kp_st_q || fifo_st_q));
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import kps_pkg::*;
#(
  parameter int NROWS = 16,
  parameter int NCOLS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic [NROWS-1:0]  row_drive_o,
  input  logic [NCOLS-1:0]  col_sense_i
);
  logic                          en, row_done, scan_done;
  logic [DEB_W-1:0]              deb;
  logic [GAP_W-1:0]              gap;
  logic [ROW_W-1:0]              row_idx;
  logic [NCOLS-1:0]              row_bits;
  logic [DEPTH-1:0][ENTRY_W-1:0] ent;
  logic [CNT_W-1:0]              cnt;

  kps_scan_seq #(.NROWS(NROWS), .NCOLS(NCOLS)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .deb_i(deb), .gap_i(gap),
    .col_i(col_sense_i), .row_o(row_drive_o), .row_done_o(row_done),
    .row_idx_o(row_idx), .row_bits_o(row_bits), .scan_done_o(scan_done));

  kps_collect #(.NCOLS(NCOLS)) col_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!en), .row_done_i(row_done),
    .row_idx_i(row_idx), .row_bits_i(row_bits), .scan_done_i(scan_done),
    .ent_o(ent), .cnt_o(cnt));

  kps_regs #(.NROWS(NROWS), .NCOLS(NCOLS)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .en_o(en), .deb_o(deb),
    .gap_o(gap), .irq_o(irq_o), .cnt_i(cnt), .ent_i(ent),
    .row_done_i(row_done), .row_idx_i(row_idx), .row_bits_i(row_bits));
endmodule

// File: tb/keymatrix_scanner_tb_top.sv
`timescale 1ns/1ps
module keymatrix_scanner_tb_top;
  localparam int NR = 4;
  localparam int NC = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_wr_i = 1'b0;
  logic [7:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          irq_o;
  logic [NR-1:0] row_drive_o;
  logic [NC-1:0] col_sense_i;
  logic [15:0]   keys = '0;
  logic [NC-1:0] glitch = '0;
  int ntests = 0;
  int nfail = 0;

  always #2.5 clk_i = ~clk_i;

  always_comb begin
    col_sense_i = '0;
    for (int r = 0; r < NR; r++)
      if (row_drive_o[r]) col_sense_i = col_sense_i | keys[r*NC +: NC];
    col_sense_i = col_sense_i & ~glitch;
  end

  keymatrix_scanner #(.NROWS(NR), .NCOLS(NC)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.1;
    d = reg_rdata_o;
  endtask

  task automatic row0_start();
    logic p;
    forever begin
      p = row_drive_o[0];
      @(negedge clk_i);
      if (row_drive_o[0] && !p) break;
    end
  endtask

  function automatic logic [31:0] ctrl(bit en, bit kp, bit ff, int deb, int thr);
    return 32'(en) | (32'(kp) << 1) | (32'(ff) << 3) | (32'(deb) << 4) | (32'(thr) << 14);
  endfunction

  task automatic check_snapshot(input logic [15:0] k, input string tag);
    logic [7:0] e [8];
    logic [31:0] w0, w1, s;
    int n = 0;
    for (int i = 0; i < 8; i++) e[i] = '0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (k[r*NC + c]) begin
          if (n < 8) e[n] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    if (n > 8) n = 8;
    rd(8'h30, w0);
    chk(w0 == {e[3], e[2], e[1], e[0]}, {tag, " R6 word0"}, w0, {e[3], e[2], e[1], e[0]});
    rd(8'h34, w1);
    chk(w1 == {e[7], e[6], e[5], e[4]}, {tag, " R7 word1"}, w1, {e[7], e[6], e[5], e[4]});
    rd(8'h04, s);
    chk(s[7:4] == 4'(n), {tag, " R7 count"}, 32'(s[7:4]), 32'(n));
  endtask

  task automatic apply_and_check(input logic [15:0] k, input string tag);
    @(negedge clk_i);
    keys = k;
    row0_start();
    row0_start();
    check_snapshot(k, tag);
  endtask

  initial begin
    #(200000 * 5);
    ntests++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int len, per;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(8'h00, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h30, v); chk(v == 0, "R1 word0", v, 0);
    rd(8'h34, v); chk(v == 0, "R1 word1", v, 0);
    chk(irq_o == 0 && row_drive_o == 0, "R1 pins", {irq_o, 4'(row_drive_o)}, 0);

    // R2 disabled: keys pressed, no scanning, nothing published
    keys = 16'h0421;
    repeat (100) begin
      @(negedge clk_i);
      if (row_drive_o != 0) break;
    end
    chk(row_drive_o == 0, "R2 rows idle", 32'(row_drive_o), 0);
    rd(8'h04, v); chk(v[7:4] == 0, "R2 no publish", 32'(v[7:4]), 0);

    // R3/R4 timing, D=0 G=0
    wr(8'h00, ctrl(1, 0, 0, 0, 0));
    row0_start();
    for (int k = 0; k < NR; k++) begin
      len = 0;
      while (row_drive_o == (NR'(1) << k)) begin len++; @(negedge clk_i); end
      chk(len == 16, "R3 dwell D=0", len, 16);
    end
    row0_start();
    per = 0;
    begin
      logic p;
      forever begin
        p = row_drive_o[0]; @(negedge clk_i); per++;
        if (row_drive_o[0] && !p) break;
      end
    end
    chk(per == 6 + NR * 16, "R4 period D=0 G=0", per, 6 + NR * 16);

    // R3/R4 timing, D=3 G=7
    wr(8'h2C, 32'd7);
    wr(8'h00, ctrl(1, 0, 0, 3, 0));
    row0_start();
    row0_start();
    for (int k = 0; k < NR; k++) begin
      len = 0;
      while (row_drive_o == (NR'(1) << k)) begin len++; @(negedge clk_i); end
      chk(len == 19, "R3 dwell D=3", len, 19);
    end
    row0_start();
    per = 0;
    begin
      logic p;
      forever begin
        p = row_drive_o[0]; @(negedge clk_i); per++;
        if (row_drive_o[0] && !p) break;
      end
    end
    chk(per == 6 + NR * 19 + 7, "R4 period D=3 G=7", per, 6 + NR * 19 + 7);
    wr(8'h2C, 32'd0);
    wr(8'h00, ctrl(1, 0, 0, 0, 0));

    // R6/R7 sweep: singles, pairs, dense patterns
    apply_and_check(16'h0000, "empty");
    for (int a = 0; a < 16; a++) apply_and_check(16'(1) << a, "single");
    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        apply_and_check((16'(1) << a) | (16'(1) << b), "pair");
    apply_and_check(16'hFFFF, "full");
    apply_and_check(16'h7FF0, "over8");
    apply_and_check(16'hF0F0, "exact8");
    apply_and_check(16'hA5A5, "mixed");

    // R5 debounce: one-cycle drop in row 2 column 1
    apply_and_check(16'h0200, "R5 pre");
    row0_start();
    while (!row_drive_o[2]) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    glitch = 4'b0010;
    @(negedge clk_i);
    glitch = '0;
    row0_start();
    rd(8'h04, v); chk(v[7:4] == 0, "R5 dropped after glitch", 32'(v[7:4]), 0);
    row0_start();
    rd(8'h30, v); chk(v == 32'h91, "R5 back next scan", v, 32'h91);

    // R9/R10 key-press status with masks
    @(negedge clk_i); keys = '0;
    wr(8'h3C, 32'hF);
    wr(8'h00, ctrl(1, 1, 0, 0, 0));
    row0_start(); row0_start();
    wr(8'h04, 32'h1);
    apply_and_check(16'h0040, "R9 masked key");
    rd(8'h04, v); chk(v[0] == 0, "R9 masked row no status", 32'(v[0]), 0);
    chk(irq_o == 0, "R10 irq low masked", 32'(irq_o), 0);
    wr(8'h3C, 32'h3);
    apply_and_check(16'h0080, "R9 open column");
    rd(8'h04, v); chk(v[0] == 1, "R9 partial mask sets", 32'(v[0]), 1);
    chk(irq_o == 1, "R10 irq high", 32'(irq_o), 1);
    apply_and_check(16'h0000, "R9 release");
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk(v[0] == 1, "R9 write 0 keeps", 32'(v[0]), 1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk(v[0] == 0, "R9 W1C clears", 32'(v[0]), 0);
    chk(irq_o == 0, "R10 irq low after clear", 32'(irq_o), 0);
    apply_and_check(16'h0100, "R9 unmasked row");
    rd(8'h04, v); chk(v[0] == 1, "R9 unmasked row sets", 32'(v[0]), 1);
    wr(8'h00, ctrl(1, 0, 0, 0, 0));
    chk(irq_o == 0, "R10 disabled source masked", 32'(irq_o), 0);
    apply_and_check(16'h0000, "clean");
    wr(8'h04, 32'h5);

    // R8 FIFO-count status, threshold 3
    wr(8'h00, ctrl(1, 0, 1, 0, 3));
    apply_and_check(16'h0003, "R8 two keys");
    rd(8'h04, v); chk(v[2] == 0, "R8 below threshold", 32'(v[2]), 0);
    chk(irq_o == 0, "R10 irq low below thr", 32'(irq_o), 0);
    apply_and_check(16'h1011, "R8 three keys");
    rd(8'h04, v); chk(v[2] == 1, "R8 at threshold", 32'(v[2]), 1);
    chk(irq_o == 1, "R10 irq fifo", 32'(irq_o), 1);
    wr(8'h04, 32'h4);
    rd(8'h04, v); chk(v[2] == 1, "R8 clear while held", 32'(v[2]), 1);
    apply_and_check(16'h0000, "R8 release");
    wr(8'h04, 32'h4);
    rd(8'h04, v); chk(v[2] == 0, "R8 W1C clears", 32'(v[2]), 0);
    chk(irq_o == 0, "R10 irq low after fifo clear", 32'(irq_o), 0);

    // R2 disable during operation
    apply_and_check(16'h0008, "R2 pre-disable");
    wr(8'h00, 32'h0);
    @(negedge clk_i); keys = 16'hFFFF;
    repeat (200) begin
      @(negedge clk_i);
      if (row_drive_o != 0) break;
    end
    chk(row_drive_o == 0, "R2 rows idle after disable", 32'(row_drive_o), 0);
    rd(8'h04, v); chk(v[7:4] == 1, "R2 snapshot frozen", 32'(v[7:4]), 1);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule